// File: doc/BRIEF.md
# Register Rename Unit with Commit-Ordered Release

This block translates the register operands of instructions in an out-of-order core from architectural to physical names, for one thread and one register class. Every request can carry two source operands and an optional destination. Each source is looked up in a mapping table, and the result is returned together with a readiness flag taken from a per-physical-register ready table. A destination receives a fresh physical register taken from a first-in first-out pool. The old mapping is reported and kept in an undo log, together with the instruction's 16-bit sequence number.

The commit port carries a sequence number. From then on, log entries are retired from the oldest end, one per clock, for as long as their sequence number is not later than that bound. Each retired entry hands the physical register it replaced back to the pool. Architectural register 0 is pinned to physical register 0. Its log entries record identical old and new mappings, and retiring such an entry releases nothing. A writeback port marks a physical register ready at the next clock edge, and it also bypasses to source lookups in the same cycle.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i and every physical register reads ready. The pool holds physical registers 32 to 63, which are handed out in ascending order.
- R2: Each source output gives the current mapping of its architectural register. Its ready flag is the stored ready bit of that physical register, OR-ed with a writeback of the same index in the same cycle.
- R3: An accepted request with a destination other than register 0 receives the oldest pool entry as its new register and reports the previous mapping. The map entry changes at the clock edge, and that register's ready bit is cleared. Sources of the same request still see the old mapping.
- R4: A destination of register 0 reports new and previous register 0, takes nothing from the pool and still logs an entry. A source of register 0 always yields physical register 0, ready.
- R5: A request with a destination is held off with busy when the log holds 32 entries, or when it needs a pool entry and the pool is empty. A held-off request changes no state. A request without a destination is never busy.
- R6: A writeback of physical register p makes p read ready from the next clock edge on.
- R7: Once a commit bound N is given, log entries are retired oldest first, at most one per clock, while the oldest entry's sequence number is not later than N. Each retired entry whose previous register differs from its new register appends the previous register to the tail of the pool. A bound earlier than every logged entry retires nothing.
- R8: Sequence numbers compare modulo 2^16: s is not later than N when (s - N) mod 2^16 is 0 or has bit 15 set.
- R9: A retired entry whose previous and new registers are equal returns nothing to the pool, so physical register 0 is never handed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rn_valid | input | 1 | Rename request present |
| rn_seq | input | 16 | Sequence number of the request |
| rn_has_dst | input | 1 | Request has a destination operand |
| rn_dst_arch | input | 5 | Destination architectural register |
| rn_src_arch | input | 2x5 | Source architectural registers |
| rn_busy | output | 1 | Request cannot be accepted this cycle |
| rn_dst_phys | output | 6 | Newly assigned physical register |
| rn_prev_phys | output | 6 | Physical register previously mapped to the destination |
| rn_src_phys | output | 2x6 | Physical registers of the sources |
| rn_src_rdy | output | 2 | Readiness of each source |
| cm_valid | input | 1 | Commit bound present |
| cm_seq | input | 16 | Newest committed sequence number |
| wb_valid | input | 1 | Writeback present |
| wb_phys | input | 6 | Physical register being written back |

## Verification
A corrupted map entry shows up on the very next lookup of that architectural register, as a wrong source or previous-register value. A fault in the pool or the log stays hidden until the pool wraps around to the damaged slot. The bench therefore runs rename and commit rounds that recycle every pool entry several times. Each handed-out register is compared against a reference pool, so a wrongly released or lost register is reported within one pool turnover. Readiness faults appear on the first source lookup that follows the rename or writeback involved.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int unsigned RR_ARCH_N = 32;
  localparam int unsigned RR_PHYS_N = 64;
  localparam int unsigned RR_SEQ_W  = 16;
  localparam int unsigned RR_HIST_N = 32;
  localparam int unsigned RR_ARCH_W = $clog2(RR_ARCH_N);
  localparam int unsigned RR_PHYS_W = $clog2(RR_PHYS_N);

  typedef logic [RR_ARCH_W-1:0] arch_idx_t;
  typedef logic [RR_PHYS_W-1:0] phys_idx_t;
  typedef logic [RR_SEQ_W-1:0]  seq_t;

  typedef struct packed {
    seq_t      seq;
    arch_idx_t arch;
    phys_idx_t newp;
    phys_idx_t prevp;
  } hist_ent_t;

  // True when a is at or before b in modulo sequence order.
  function automatic logic seq_not_after(seq_t a, seq_t b);
    seq_t d;
    d = a - b;
    return d[RR_SEQ_W-1] || (d == '0);
  endfunction
endpackage

// File: rtl/rr_free_list.sv
module rr_free_list
  import rr_pkg::*;
#(
  parameter int unsigned PHYS_N = RR_PHYS_N,
  parameter int unsigned ARCH_N = RR_ARCH_N
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pop,
  input  logic                         push,
  input  phys_idx_t                    push_idx,
  output phys_idx_t                    head_idx,
  output logic                         empty,
  output logic [$clog2(PHYS_N):0]      count
);
  localparam int unsigned PW     = $clog2(PHYS_N);
  localparam int unsigned INIT_N = PHYS_N - ARCH_N;

  phys_idx_t         slot_q [PHYS_N];
  logic [PW-1:0]     rd_q, rd_d;
  logic [PW-1:0]     wr_q, wr_d;
  logic [PW:0]       cnt_q, cnt_d;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (pop) begin
      rd_d = rd_q + 1'b1;
    end
    if (push) begin
      wr_d = wr_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= PW'(INIT_N);
      cnt_q <= (PW+1)'(INIT_N);
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(PHYS_N); i++) begin
        slot_q[i] <= (i < int'(INIT_N)) ? phys_idx_t'(int'(ARCH_N) + i) : '0;
      end
    end else if (push) begin
      slot_q[wr_q] <= push_idx;
    end
  end

  assign head_idx = slot_q[rd_q];
  assign empty    = (cnt_q == '0);
  assign count    = cnt_q;
endmodule

// File: rtl/rr_scoreboard.sv
module rr_scoreboard
  import rr_pkg::*;
#(
  parameter int unsigned PHYS_N = RR_PHYS_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  phys_idx_t         set_idx,
  input  logic              clr_en,
  input  phys_idx_t         clr_idx,
  output logic [PHYS_N-1:0] rdy_bits
);
  logic [PHYS_N-1:0] bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    if (set_en) begin
      bits_d[set_idx] = 1'b1;
    end
    if (clr_en) begin
      bits_d[clr_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '1;
    end else if (set_en || clr_en) begin
      bits_q <= bits_d;
    end
  end

  assign rdy_bits = bits_q;
endmodule

// File: rtl/rr_history.sv
module rr_history
  import rr_pkg::*;
#(
  parameter int unsigned DEPTH = RR_HIST_N
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  hist_ent_t                  push_ent,
  input  logic                       cm_valid,
  input  seq_t                       cm_seq,
  output logic                       retire,
  output hist_ent_t                  retire_ent,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int unsigned AW = $clog2(DEPTH);

  hist_ent_t     ent_q [DEPTH];
  logic [AW-1:0] old_q, old_d;
  logic [AW-1:0] new_q, new_d;
  logic [AW:0]   cnt_q, cnt_d;
  seq_t          bound_q;
  logic          bound_vld_q;

  assign retire_ent = ent_q[old_q];
  assign retire     = bound_vld_q && (cnt_q != '0) &&
                      seq_not_after(retire_ent.seq, bound_q);

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    old_d = retire ? ptr_inc(old_q) : old_q;
    new_d = push   ? ptr_inc(new_q) : new_q;
    case ({push, retire})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q       <= '0;
      new_q       <= '0;
      cnt_q       <= '0;
      bound_q     <= '0;
      bound_vld_q <= 1'b0;
    end else begin
      old_q <= old_d;
      new_q <= new_d;
      cnt_q <= cnt_d;
      if (cm_valid) begin
        bound_q     <= cm_seq;
        bound_vld_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        ent_q[i] <= '0;
      end
    end else if (push) begin
      ent_q[new_q] <= push_ent;
    end
  end

  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign count = cnt_q;
endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit
  import rr_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 2,
  parameter int unsigned ARCH_N     = RR_ARCH_N,
  parameter int unsigned PHYS_N     = RR_PHYS_N,
  parameter int unsigned HIST_DEPTH = RR_HIST_N
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  rn_valid,
  input  logic [RR_SEQ_W-1:0]                   rn_seq,
  input  logic                                  rn_has_dst,
  input  logic [RR_ARCH_W-1:0]                  rn_dst_arch,
  input  logic [NUM_SRC-1:0][RR_ARCH_W-1:0]     rn_src_arch,
  output logic                                  rn_busy,
  output logic [RR_PHYS_W-1:0]                  rn_dst_phys,
  output logic [RR_PHYS_W-1:0]                  rn_prev_phys,
  output logic [NUM_SRC-1:0][RR_PHYS_W-1:0]     rn_src_phys,
  output logic [NUM_SRC-1:0]                    rn_src_rdy,
  input  logic                                  cm_valid,
  input  logic [RR_SEQ_W-1:0]                   cm_seq,
  input  logic                                  wb_valid,
  input  logic [RR_PHYS_W-1:0]                  wb_phys
);
  localparam int unsigned FL_CW = $clog2(PHYS_N) + 1;
  localparam int unsigned HB_CW = $clog2(HIST_DEPTH) + 1;

  phys_idx_t          map_q [ARCH_N];
  phys_idx_t          fl_head;
  logic               fl_empty;
  logic [FL_CW-1:0]   fl_count;
  logic               hist_full;
  logic [HB_CW-1:0]   hist_count;
  logic               retire;
  hist_ent_t          retire_ent;
  hist_ent_t          log_ent;
  logic [PHYS_N-1:0]  sb_bits;

  logic needs_phys, fire, alloc, log_push, release_prev;
  logic map_we;

  // Request decode
  assign needs_phys   = rn_has_dst && (rn_dst_arch != '0);
  assign rn_busy      = rn_valid && rn_has_dst &&
                        (hist_full || (needs_phys && fl_empty));
  assign fire         = rn_valid && !rn_busy;
  assign alloc        = fire && needs_phys;
  assign log_push     = fire && rn_has_dst;
  assign map_we       = alloc;
  assign rn_dst_phys  = needs_phys ? fl_head : '0;
  assign rn_prev_phys = rn_has_dst ? map_q[rn_dst_arch] : '0;
  assign release_prev = retire && (retire_ent.prevp != retire_ent.newp);

  always_comb begin
    log_ent       = '0;
    log_ent.seq   = rn_seq;
    log_ent.arch  = rn_dst_arch;
    log_ent.newp  = rn_dst_phys;
    log_ent.prevp = rn_prev_phys;
  end

  // Source lookup with same-cycle writeback bypass
  for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_src
    phys_idx_t src_p;
    assign src_p          = map_q[rn_src_arch[g]];
    assign rn_src_phys[g] = src_p;
    assign rn_src_rdy[g]  = sb_bits[src_p] || (wb_valid && (wb_phys == src_p));
  end

  // Mapping table
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(ARCH_N); i++) begin
        map_q[i] <= phys_idx_t'(i);
      end
    end else if (map_we) begin
      map_q[rn_dst_arch] <= fl_head;
    end
  end

  rr_free_list #(
    .PHYS_N (PHYS_N),
    .ARCH_N (ARCH_N)
  ) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc),
    .push     (release_prev),
    .push_idx (retire_ent.prevp),
    .head_idx (fl_head),
    .empty    (fl_empty),
    .count    (fl_count)
  );

  rr_scoreboard #(
    .PHYS_N (PHYS_N)
  ) u_ready (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (wb_valid),
    .set_idx  (wb_phys),
    .clr_en   (alloc),
    .clr_idx  (fl_head),
    .rdy_bits (sb_bits)
  );

  rr_history #(
    .DEPTH (HIST_DEPTH)
  ) u_log (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (log_push),
    .push_ent   (log_ent),
    .cm_valid   (cm_valid),
    .cm_seq     (cm_seq),
    .retire     (retire),
    .retire_ent (retire_ent),
    .full       (hist_full),
    .count      (hist_count)
  );
endmodule

// File: rtl/rr_checks.sv
module rr_checks
  import rr_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 2,
  parameter int unsigned PHYS_N     = RR_PHYS_N,
  parameter int unsigned HIST_DEPTH = RR_HIST_N
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              rn_valid,
  input logic                              rn_has_dst,
  input logic [RR_ARCH_W-1:0]              rn_dst_arch,
  input logic [NUM_SRC-1:0][RR_ARCH_W-1:0] rn_src_arch,
  input logic                              rn_busy,
  input logic [RR_PHYS_W-1:0]              rn_dst_phys,
  input logic [RR_PHYS_W-1:0]              rn_prev_phys,
  input logic [NUM_SRC-1:0][RR_PHYS_W-1:0] rn_src_phys,
  input logic [NUM_SRC-1:0]                rn_src_rdy,
  input logic                              wb_valid,
  input logic [RR_PHYS_W-1:0]              wb_phys,
  input logic [$clog2(PHYS_N):0]           fl_count,
  input logic [$clog2(HIST_DEPTH):0]       hist_count,
  input logic [PHYS_N-1:0]                 sb_bits
);
  logic take;
  assign take = rn_valid && !rn_busy && rn_has_dst && (rn_dst_arch != '0);

  a_r5_busy_pool_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_valid && rn_has_dst && rn_dst_arch != '0 && fl_count == '0) |-> rn_busy);

  a_r5_busy_log_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_valid && rn_has_dst && hist_count == ($clog2(HIST_DEPTH)+1)'(HIST_DEPTH)) |-> rn_busy);

  a_r5_no_dst_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_valid && !rn_has_dst) |-> !rn_busy);

  a_r4_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_valid && rn_has_dst && rn_dst_arch == '0) |-> (rn_dst_phys == '0 && rn_prev_phys == '0));

  a_r3_alloc_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !sb_bits[$past(rn_dst_phys)]);

  a_r6_wb_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(take && rn_dst_phys == wb_phys)) |=> sb_bits[$past(wb_phys)]);

  a_r9_no_zero_handout: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> rn_dst_phys != '0);

  a_r7_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_count <= ($clog2(PHYS_N)+1)'(PHYS_N)) &&
    (hist_count <= ($clog2(HIST_DEPTH)+1)'(HIST_DEPTH)));

  for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_src_chk
    a_r4_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_src_arch[g] == '0) |-> (rn_src_phys[g] == '0 && rn_src_rdy[g]));
  end
endmodule

bind reg_rename_unit rr_checks #(
  .NUM_SRC    (NUM_SRC),
  .PHYS_N     (PHYS_N),
  .HIST_DEPTH (HIST_DEPTH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rn_valid     (rn_valid),
  .rn_has_dst   (rn_has_dst),
  .rn_dst_arch  (rn_dst_arch),
  .rn_src_arch  (rn_src_arch),
  .rn_busy      (rn_busy),
  .rn_dst_phys  (rn_dst_phys),
  .rn_prev_phys (rn_prev_phys),
  .rn_src_phys  (rn_src_phys),
  .rn_src_rdy   (rn_src_rdy),
  .wb_valid     (wb_valid),
  .wb_phys      (wb_phys),
  .fl_count     (fl_count),
  .hist_count   (hist_count),
  .sb_bits      (sb_bits)
);

// File: tb/sim_reg_rename_unit.sv
module sim_reg_rename_unit;
  localparam int CLK_PERIOD = 10;

  logic            clk;
  logic            rst_n;
  logic            rn_valid;
  logic [15:0]     rn_seq;
  logic            rn_has_dst;
  logic [4:0]      rn_dst_arch;
  logic [1:0][4:0] rn_src_arch;
  logic            rn_busy;
  logic [5:0]      rn_dst_phys;
  logic [5:0]      rn_prev_phys;
  logic [1:0][5:0] rn_src_phys;
  logic [1:0]      rn_src_rdy;
  logic            cm_valid;
  logic [15:0]     cm_seq;
  logic            wb_valid;
  logic [5:0]      wb_phys;

  reg_rename_unit u0 (
    .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_seq(rn_seq),
    .rn_has_dst(rn_has_dst), .rn_dst_arch(rn_dst_arch), .rn_src_arch(rn_src_arch),
    .rn_busy(rn_busy), .rn_dst_phys(rn_dst_phys), .rn_prev_phys(rn_prev_phys),
    .rn_src_phys(rn_src_phys), .rn_src_rdy(rn_src_rdy), .cm_valid(cm_valid),
    .cm_seq(cm_seq), .wb_valid(wb_valid), .wb_phys(wb_phys)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Reference model
  int mdl_map [32];
  bit mdl_rdy [64];
  int mdl_pool [$];
  int h_seq [$];
  int h_new [$];
  int h_prev [$];
  int cur_seq;

  function automatic bit not_after(int a, int b);
    int d;
    d = (a - b) & 16'hFFFF;
    return (d == 0) || (d >= 32768);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_rn(input string req, input bit has, input int dst,
                       input int s0, input int s1, input bit wbv = 0, input int wbp = 0);
    bit exp_busy;
    int newp;
    exp_busy = has && (h_seq.size() == 32 || (dst != 0 && mdl_pool.size() == 0));
    rn_valid    = 1'b1;
    rn_seq      = 16'(cur_seq);
    rn_has_dst  = has;
    rn_dst_arch = 5'(dst);
    rn_src_arch[0] = 5'(s0);
    rn_src_arch[1] = 5'(s1);
    wb_valid    = wbv;
    wb_phys     = 6'(wbp);
    @(negedge clk);
    chk(req, "busy", int'(rn_busy), int'(exp_busy));
    if (!exp_busy) begin
      chk(req, "src0 phys", int'(rn_src_phys[0]), mdl_map[s0]);
      chk(req, "src1 phys", int'(rn_src_phys[1]), mdl_map[s1]);
      chk(req, "src0 rdy", int'(rn_src_rdy[0]),
          int'(mdl_rdy[mdl_map[s0]] || (wbv && wbp == mdl_map[s0])));
      chk(req, "src1 rdy", int'(rn_src_rdy[1]),
          int'(mdl_rdy[mdl_map[s1]] || (wbv && wbp == mdl_map[s1])));
      if (has) begin
        newp = (dst != 0) ? mdl_pool[0] : 0;
        chk(req, "dst phys", int'(rn_dst_phys), newp);
        chk(req, "prev phys", int'(rn_prev_phys), mdl_map[dst]);
      end
    end
    @(posedge clk);
    #1;
    rn_valid = 1'b0;
    wb_valid = 1'b0;
    if (wbv) mdl_rdy[wbp] = 1'b1;
    if (!exp_busy && has) begin
      newp = 0;
      if (dst != 0) begin
        newp = mdl_pool.pop_front();
        mdl_rdy[newp] = 1'b0;
      end
      h_seq.push_back(cur_seq);
      h_new.push_back(newp);
      h_prev.push_back(mdl_map[dst]);
      if (dst != 0) mdl_map[dst] = newp;
    end
    if (!exp_busy) cur_seq = (cur_seq + 1) & 16'hFFFF;
  endtask

  task automatic do_cm(input int n);
    cm_valid = 1'b1;
    cm_seq   = 16'(n);
    @(posedge clk);
    #1;
    cm_valid = 1'b0;
    repeat (40) @(posedge clk);
    #1;
    while (h_seq.size() > 0 && not_after(h_seq[0], n)) begin
      if (h_prev[0] != h_new[0]) mdl_pool.push_back(h_prev[0]);
      void'(h_seq.pop_front());
      void'(h_new.pop_front());
      void'(h_prev.pop_front());
    end
  endtask

  task automatic do_wb(input int p);
    wb_valid = 1'b1;
    wb_phys  = 6'(p);
    @(posedge clk);
    #1;
    wb_valid = 1'b0;
    mdl_rdy[p] = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int first_seq;
    rst_n = 1'b0; rn_valid = 1'b0; rn_seq = '0; rn_has_dst = 1'b0;
    rn_dst_arch = '0; rn_src_arch = '0; cm_valid = 1'b0; cm_seq = '0;
    wb_valid = 1'b0; wb_phys = '0;
    for (int i = 0; i < 32; i++) mdl_map[i] = i;
    for (int i = 0; i < 64; i++) mdl_rdy[i] = 1'b1;
    for (int i = 32; i < 64; i++) mdl_pool.push_back(i);
    cur_seq = 16'hFFF0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R1: reset mapping sweep, all ready, no busy
    for (int i = 0; i < 16; i++) do_rn("R1", 0, 0, i, 31 - i);
    // R4: zero source
    do_rn("R4", 0, 0, 0, 0);

    // R3: fill all 32 pool entries; sources include the destination itself
    first_seq = cur_seq;
    for (int i = 0; i < 32; i++) do_rn("R3", 1, (i % 31) + 1, (i % 31) + 1, (i % 30) + 2);

    // R5: log full and pool empty
    do_rn("R5", 1, 5, 1, 2);
    do_rn("R5", 1, 0, 1, 2);
    do_rn("R5", 0, 0, 3, 4);

    // R2 bypass, then R6 stored ready
    do_rn("R2", 0, 0, 2, 3, 1, mdl_map[2]);
    do_rn("R6", 0, 0, 2, 3);
    do_wb(mdl_map[3]);
    do_rn("R6", 0, 0, 3, 2);

    // R7: bound earlier than every entry retires nothing
    do_cm((first_seq - 1) & 16'hFFFF);
    do_rn("R7", 1, 4, 4, 1);

    // R7: retire five, pool refills in order
    do_cm((first_seq + 4) & 16'hFFFF);
    do_rn("R7", 1, 7, 7, 2);
    // R4: zero destination
    do_rn("R4", 1, 0, 0, 7);

    // R8: bound past the wrap point
    do_cm(16'h0005);
    do_rn("R8", 1, 9, 9, 1);
    do_rn("R8", 1, 10, 9, 10);

    // R9: recycle the pool several times; a released register 0 would surface
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 30; i++) begin
        if (i % 7 == 3) do_rn("R9", 1, 0, i % 32, 0);
        else if (i % 5 == 0) do_rn("R9", 1, (i + r) % 31 + 1, i % 32, (i + 3) % 32, 1, mdl_map[(i + 3) % 32]);
        else do_rn("R9", 1, (i + r) % 31 + 1, i % 32, (i + 3) % 32);
      end
      do_cm((cur_seq - 1) & 16'hFFFF);
    end
    // R5: request without destination with log full stays accepted
    for (int i = 0; i < 33; i++) do_rn("R5", 1, (i % 31) + 1, i % 32, 1);
    do_rn("R5", 0, 0, 6, 8);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule